// File: doc/BRIEF.md
# Dual-Tap Line Delay Memory

This block is a line buffer for raster image pipelines. A pixel stream written on one clock comes back on a second, independent clock at two taps: one delayed by a line and one delayed by two lines. A filter or error-diffusion stage can then see three neighbouring rows at once. The first store is filled from the input port on the write clock. The second store is filled on the read clock, from the words read out of the first store.

There are no full or empty flags. Each store has its own address counters, driven by an active-low enable and an active-low reset strobe in each clock domain. The line length is the spacing between reset pulses, up to the store depth, and every counter wraps at the store depth. One read-side reset clears the first store's read counter and both counters of the second store. This keeps the two taps aligned. When reads are disabled, the outputs are modelled as high impedance: a valid flag goes low and both data buses read zero.

Top module: `dual_tap_line_delay`

## Requirements
- R1: Each store holds DEPTH words of DATA_W bits. Every address counter steps from DEPTH-1 back to 0, so a write-pointer reset, followed by DEPTH cycles with both enables low, returns the first word on oneLineQ exactly DEPTH read cycles after it was written.
- R2: On a write-clock rising edge with wrEnN low and the write side out of reset, wrData is stored at the write pointer and the write pointer advances by one.
- R3: On a write-clock edge with wrEnN high, nothing is stored and the write pointer keeps its value. Later reads show that the word at that position was not replaced.
- R4: While wrRstN is low, every write-clock edge clears the write pointer and stores nothing, even with wrEnN low. The reset passes through a two-stage synchroniser, so after wrRstN rises the next two edges still clear and the third edge is the first that can store.
- R5: On a read-clock edge with rdEnN low and the read side out of reset, oneLineQ takes the first-store word at the first read pointer. The read pointer advances, and outValid is high after that edge.
- R6: On that same edge, the word read from the first store is written into the second store at its write pointer, and twoLineQ takes the second-store word at its read pointer. A read of an address that is being written on the same edge returns the word held before the edge.
- R7: On a read-clock edge with rdEnN high, outValid goes low and both read pointers and the second-store write pointer hold. The second store is not written. While outValid is low, oneLineQ and twoLineQ both read 0.
- R8: While rdRstN is low, every read-clock edge clears the first-store read pointer and both second-store pointers, drops outValid and performs no read, even with rdEnN low. The release timing is the same as in R4.
- R9: When both resets are pulsed together and both enables are held low, oneLineQ repeats the input from one reset interval earlier and twoLineQ from two intervals earlier. An interval is at most DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrRstN | input | 1 | Active-low write pointer reset strobe |
| wrEnN | input | 1 | Active-low write enable |
| wrData | input | DATA_W | Pixel word to store |
| rdClk | input | 1 | Read-side clock, independent of wrClk |
| rdRstN | input | 1 | Active-low reset of all read-side pointers |
| rdEnN | input | 1 | Active-low read enable |
| oneLineQ | output | DATA_W | One-line delayed word, 0 while outValid is low |
| twoLineQ | output | DATA_W | Two-line delayed word, 0 while outValid is low |
| outValid | output | 1 | High when the taps carry driven data |

## Verification
The properties assume four things about the inputs:
- Each reset strobe is asserted before the block is used.
- Each strobe is held for at least one clock edge of its own domain.
- Enables and resets change away from the active edges.
- A first-store address is never read and written in the same instant from unrelated clocks.

The bench satisfies all four. It drives every input on the falling edge. It asserts both resets before the first rising edge. It ties both clock ports to one 125 MHz clock, so that a same-address read and write in the first store follow the defined read-before-write order. The stimulus then varies the enables pseudo-randomly, pulses the resets together and apart, and shortens the line below DEPTH.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  // Per-cycle strobes handed from the control to the datapath.
  typedef struct packed {
    logic storeWrite;  // write-domain: store wrData into the first store
    logic readFire;    // read-domain: read both stores, copy into the second
  } ldmStrobe_t;
endpackage

// File: rtl/ldm_line_store.sv
module ldm_line_store #(
  parameter int DEPTH  = 5120,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdWord
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wrClk) begin
    if (wrEn) cells[wrAddr] <= wrData;
  end

  // Unregistered read: the owner samples it on its own clock edge, so a
  // write landing on the same edge is not yet visible.
  assign rdWord = cells[rdAddr];
endmodule

// File: rtl/ldm_rst_sync.sv
module ldm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rawRstN,
  output logic syncRstN
);
  logic [STAGES-1:0] stages;

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) stages <= '0;
    else          stages <= {stages[STAGES-2:0], 1'b1};
  end

  assign syncRstN = stages[STAGES-1];
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int DEPTH       = 5120,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrEnN,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEnN,
  output ldmStrobe_t    strobe,
  output logic [AW-1:0] wr1Addr,
  output logic [AW-1:0] rd1Addr,
  output logic [AW-1:0] wr2Addr,
  output logic [AW-1:0] rd2Addr,
  output logic          outValid,
  output logic          wrRstSync,
  output logic          rdRstSync
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  ldm_rst_sync #(.STAGES(SYNC_STAGES)) u_wrSync (
    .clk(wrClk), .rawRstN(wrRstN), .syncRstN(wrRstSync)
  );
  ldm_rst_sync #(.STAGES(SYNC_STAGES)) u_rdSync (
    .clk(rdClk), .rawRstN(rdRstN), .syncRstN(rdRstSync)
  );

  logic wrGo;
  logic rdGo;

  // Reset outranks enable in each domain.
  assign wrGo = wrRstSync && !wrEnN;
  assign rdGo = rdRstSync && !rdEnN;

  assign strobe.storeWrite = wrGo;
  assign strobe.readFire   = rdGo;

  // Write domain: first-store write pointer.
  always_ff @(posedge wrClk) begin
    if (!wrRstSync)  wr1Addr <= '0;
    else if (wrGo)   wr1Addr <= stepAddr(wr1Addr);
  end

  // Read domain: first-store read pointer and both second-store pointers.
  always_ff @(posedge rdClk) begin
    if (!rdRstSync) begin
      rd1Addr  <= '0;
      wr2Addr  <= '0;
      rd2Addr  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= rdGo;
      if (rdGo) begin
        rd1Addr <= stepAddr(rd1Addr);
        wr2Addr <= stepAddr(wr2Addr);
        rd2Addr <= stepAddr(rd2Addr);
      end
    end
  end
endmodule

// File: rtl/ldm_datapath.sv
module ldm_datapath
  import ldm_pkg::*;
#(
  parameter int DEPTH  = 5120,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  ldmStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     wr1Addr,
  input  logic [AW-1:0]     rd1Addr,
  input  logic [AW-1:0]     wr2Addr,
  input  logic [AW-1:0]     rd2Addr,
  output logic [DATA_W-1:0] tap1Reg,
  output logic [DATA_W-1:0] tap2Reg
);
  logic [DATA_W-1:0] word1;
  logic [DATA_W-1:0] word2;

  // First store: filled from the input port in the write domain.
  ldm_line_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_store1 (
    .wrClk(wrClk), .wrEn(strobe.storeWrite), .wrAddr(wr1Addr),
    .wrData(wrData), .rdAddr(rd1Addr), .rdWord(word1)
  );

  // Second store: filled from the first store's read word in the read domain.
  ldm_line_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_store2 (
    .wrClk(rdClk), .wrEn(strobe.readFire), .wrAddr(wr2Addr),
    .wrData(word1), .rdAddr(rd2Addr), .rdWord(word2)
  );

  always_ff @(posedge rdClk) begin
    if (strobe.readFire) begin
      tap1Reg <= word1;
      tap2Reg <= word2;
    end
  end
endmodule

// File: rtl/dual_tap_line_delay.sv
module dual_tap_line_delay
  import ldm_pkg::*;
#(
  parameter int DEPTH       = 5120,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] oneLineQ,
  output logic [DATA_W-1:0] twoLineQ,
  output logic              outValid
);
  localparam int AW = $clog2(DEPTH);

  ldmStrobe_t        strobe;
  logic [AW-1:0]     wr1Addr;
  logic [AW-1:0]     rd1Addr;
  logic [AW-1:0]     wr2Addr;
  logic [AW-1:0]     rd2Addr;
  logic              wrRstSync;
  logic              rdRstSync;
  logic [DATA_W-1:0] tap1Reg;
  logic [DATA_W-1:0] tap2Reg;

  ldm_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES), .AW(AW)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEnN(wrEnN),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEnN(rdEnN),
    .strobe(strobe), .wr1Addr(wr1Addr), .rd1Addr(rd1Addr),
    .wr2Addr(wr2Addr), .rd2Addr(rd2Addr), .outValid(outValid),
    .wrRstSync(wrRstSync), .rdRstSync(rdRstSync)
  );

  ldm_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_datapath (
    .wrClk(wrClk), .rdClk(rdClk), .strobe(strobe), .wrData(wrData),
    .wr1Addr(wr1Addr), .rd1Addr(rd1Addr), .wr2Addr(wr2Addr),
    .rd2Addr(rd2Addr), .tap1Reg(tap1Reg), .tap2Reg(tap2Reg)
  );

  // Undriven taps are represented as zero with outValid low.
  assign oneLineQ = outValid ? tap1Reg : '0;
  assign twoLineQ = outValid ? tap2Reg : '0;
endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
  parameter int DEPTH = 5120,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          wrClk,
  input logic          wrRstN,
  input logic          wrEnN,
  input logic          wrRstSync,
  input logic          rdClk,
  input logic          rdRstN,
  input logic          rdEnN,
  input logic          rdRstSync,
  input logic          outValid,
  input logic [AW-1:0] wr1Addr,
  input logic [AW-1:0] rd1Addr,
  input logic [AW-1:0] wr2Addr,
  input logic [AW-1:0] rd2Addr
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  AST_WR_WRAP: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrRstSync && !wrEnN && wr1Addr == LAST_ADDR) |=> (wr1Addr == '0)); // R1

  AST_WR_ADVANCE: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrRstSync && !wrEnN && wr1Addr != LAST_ADDR) |=>
      (wr1Addr == AW'($past(wr1Addr) + 1'b1))); // R2

  AST_WR_HOLD: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrRstSync && wrEnN) |=> $stable(wr1Addr)); // R3

  AST_WR_CLEAR: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !wrRstSync |=> (wr1Addr == '0)); // R4

  AST_RD_VALID: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdRstSync && !rdEnN) |=> outValid); // R5

  AST_TAP_ALIGN: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (wr2Addr == rd2Addr)); // R6

  AST_RD_IDLE: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdRstSync && rdEnN) |=>
      (!outValid && $stable(rd1Addr) && $stable(wr2Addr))); // R7

  AST_RD_CLEAR: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdRstSync |=> (rd1Addr == '0 && rd2Addr == '0 && !outValid)); // R8

  AST_RD_WRAP: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdRstSync && !rdEnN && rd1Addr == LAST_ADDR) |=> (rd1Addr == '0)); // R1
endmodule

bind dual_tap_line_delay ldm_checker #(.DEPTH(DEPTH)) u_ldm_checker (
  .wrClk(wrClk), .wrRstN(wrRstN), .wrEnN(wrEnN), .wrRstSync(wrRstSync),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdEnN(rdEnN), .rdRstSync(rdRstSync),
  .outValid(outValid), .wr1Addr(wr1Addr), .rd1Addr(rd1Addr),
  .wr2Addr(wr2Addr), .rd2Addr(rd2Addr)
);

// File: tb/test_dual_tap_line_delay.sv
module test_dual_tap_line_delay;
  localparam int D = 12;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz, both ports

  logic         wrEnN = 1'b1, wrRstN = 1'b1, rdEnN = 1'b1, rdRstN = 1'b1;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] oneLineQ, twoLineQ;
  logic         outValid;

  dual_tap_line_delay #(.DEPTH(D), .DATA_W(W)) i_dual_tap_line_delay (
    .wrClk(clk), .wrRstN(wrRstN), .wrEnN(wrEnN), .wrData(wrData),
    .rdClk(clk), .rdRstN(rdRstN), .rdEnN(rdEnN),
    .oneLineQ(oneLineQ), .twoLineQ(twoLineQ), .outValid(outValid)
  );

  // ---------------- behavioural reference ----------------
  int    m1[D], m2[D];
  bit    k1[D], k2[D];
  int    w1 = 0, r1 = 0, p2 = 0, wCnt = 0, rCnt = 0;
  int    expQ1 = 0, expQ2 = 0;
  bit    expK1 = 0, expK2 = 0, expOe = 0;
  bit    started = 0, done = 0;
  int    total = 0, failed = 0;
  string phase = "R4";
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) begin
    bit wAct, rAct;
    if (!wrRstN) wCnt = 0;
    if (!rdRstN) rCnt = 0;
    wAct = wrRstN && (wCnt >= 2);   // R4: two edges of synchroniser latency
    rAct = rdRstN && (rCnt >= 2);   // R8
    if (wrRstN && wCnt < 2) wCnt++;
    if (rdRstN && rCnt < 2) rCnt++;
    // read side first: same-edge writes are not visible (R6)
    if (!rAct) begin
      r1 = 0; p2 = 0; expOe = 0;
    end else if (!rdEnN) begin
      expQ1 = m1[r1]; expK1 = k1[r1];
      expQ2 = m2[p2]; expK2 = k2[p2];
      m2[p2] = m1[r1]; k2[p2] = k1[r1];
      r1 = (r1 + 1) % D; p2 = (p2 + 1) % D;
      expOe = 1;
    end else begin
      expOe = 0;
    end
    if (!wAct) w1 = 0;
    else if (!wrEnN) begin
      m1[w1] = int'(wrData); k1[w1] = 1; w1 = (w1 + 1) % D;
    end
    started = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d",
               req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R7", int'(outValid), int'(expOe));
      if (expOe) begin
        if (expK1) chk("R5", int'(oneLineQ), expQ1);
        if (expK2) chk("R6", int'(twoLineQ), expQ2);
      end else begin
        chk("R7", int'(oneLineQ), 0);
        chk("R7", int'(twoLineQ), 0);
      end
    end
  end

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]);
  endfunction

  task automatic drive(input bit we, input bit wr, input bit re, input bit rr,
                       input int data);
    @(negedge clk);
    wrEnN = we; wrRstN = wr; rdEnN = re; rdRstN = rr; wrData = W'(data);
  endtask

  initial begin
    #1 wrRstN = 1'b0; rdRstN = 1'b0;
    phase = "R4";
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 1, 0);
    phase = "R1";
    for (int i = 0; i < 3 * D + 4; i++) drive(0, 1, 0, 1, i + 1);
    phase = "R9";
    for (int i = 0; i < 42; i++)
      drive(0, (i % 7) != 0, 0, (i % 7) != 0, 100 + i);
    phase = "R3";
    for (int i = 0; i < 40; i++) drive(rnd() % 2 == 1, 1, 0, 1, rnd());
    phase = "R7";
    for (int i = 0; i < 40; i++) drive(0, 1, rnd() % 2 == 1, 1, rnd());
    phase = "R2";
    for (int i = 0; i < 60; i++)
      drive(rnd() % 2 == 1, 1, rnd() % 3 == 0, 1, rnd());
    phase = "R8";
    drive(0, 1, 0, 0, 7);
    for (int i = 0; i < 30; i++) drive(0, 1, 0, 1, rnd());
    phase = "R4";
    drive(0, 0, 0, 1, 9);
    for (int i = 0; i < 30; i++) drive(0, 1, 0, 1, rnd());
    drive(1, 1, 1, 1, 0);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(8 * 100000);
    done = 1;
    total++; failed++;
    $display("FAIL R9 watchdog: actual %0d cycles expected fewer than %0d",
             100000, 100000);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule